// File: doc/BRIEF.md
# AHB-Lite Burst Splitter

This block is the slave front end of one data port of a memory controller. It takes 32-bit AHB-lite transfers (single beats, fixed-length incrementing bursts, wrapping bursts and incrementing bursts of unspecified length) and turns them into block commands for a memory core. Each command carries a start address, a length in bytes and a direction flag, and is passed on with a valid/ready handshake. Write data goes to the core on a stream with a last flag. Read data comes back from the core on a second stream.

Two configuration inputs set the block size in bytes: one for reads and one for writes. An unspecified-length burst is cut into blocks of that size. Only one block is in flight at a time. The next command is raised only once every data word of the current block has moved. A burst that stops before its block is full closes that block. On a write the last word is flagged. On a read the surplus words the core still returns are thrown away.

Top module: `ahb_burst_splitter`

## Requirements
- R1: While reset is asserted and right after it, hreadyout is 1 and cmd_valid, wd_valid and rd_ready are 0.
- R2: hresp stays 0 (OKAY) at all times; the port never stalls a transfer with a retry or split response.
- R3: For an unspecified-length burst (hburst=1), every command has the normalised size for its direction as its length. Its address is the burst start address plus the bytes already issued in that burst.
- R4: The size inputs are normalised before use: bits [1:0] are cleared, a result of 0 becomes 4, and anything above 1024 becomes 1024. Every command length is a nonzero multiple of 4 that is no greater than 1024.
- R5: A write command is raised only after the core has taken the last write word of the previous block. No command is raised while a block's data is still moving.
- R6: A read command is raised only after the core has returned every word of the previous read block, including words that are discarded.
- R7: A write burst that ends before its block is full puts wd_last=1 on its final word. The core then receives no further data for that block.
- R8: Read words beyond an early end of a burst are consumed with rd_ready=1 and never appear on hrdata. The next transfer returns its own data.
- R9: hburst codes set the block length. SINGLE (0) gives 4 bytes. INCR4/8/16 (3/5/7) give 4 times the beat count, capped at the size input and split further when larger. Wrapping codes (2/4/6) issue one 4-byte block per beat.
- R10: During a data phase, hreadyout stays 0 until the command is accepted and that beat's word has moved. Write words are taken from hwdata and read words are presented on hrdata.
- R11: While cmd_valid=1 and cmd_ready=0, cmd_valid stays 1 and cmd_addr, cmd_len and cmd_write hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | 1 = write transfer |
| hburst | input | 3 | Burst kind |
| hwdata | input | 32 | Write data |
| hready_in | input | 1 | Bus ready seen by the slave |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data |
| rd_size_cfg | input | 11 | Read block size in bytes |
| wr_size_cfg | input | 11 | Write block size in bytes |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by core |
| cmd_addr | output | 32 | Block start address |
| cmd_len | output | 11 | Block length in bytes |
| cmd_write | output | 1 | 1 = write block |
| wd_valid | output | 1 | Write word valid |
| wd_ready | input | 1 | Core takes write word |
| wd_data | output | 32 | Write word |
| wd_last | output | 1 | Final word of the block |
| rd_valid | input | 1 | Read word valid |
| rd_ready | output | 1 | Block takes read word |
| rd_data | input | 32 | Read word |

## Verification
The bench targets block boundaries inside long bursts. A splitter that miscounts beats or drops the issued-byte offset would produce wrong command addresses, or write data to the wrong words. Bursts are ended partway through a block. A design that does not close a write block there would leave the core waiting for data. One that does not drain surplus read words would return stale data to the next, unrelated read. Size inputs of 0, 13 and 2000 exercise the normalisation limits. A core model with stalled command and data handshakes counts any command that appears while a block is still moving, which catches a design that sends the next block too early.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_XFER = 2'd2
    } split_state_e;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_BUSY   = 2'b01;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

    // beats carried by a fixed-length burst kind; single, incr and wrap give one
    function automatic logic [4:0] fixed_beats(input logic [2:0] kind);
        case (kind)
            3'd3:    fixed_beats = 5'd4;
            3'd5:    fixed_beats = 5'd8;
            3'd7:    fixed_beats = 5'd16;
            default: fixed_beats = 5'd1;
        endcase
    endfunction

    function automatic logic is_wrap(input logic [2:0] kind);
        is_wrap = (kind == 3'd2) || (kind == 3'd4) || (kind == 3'd6);
    endfunction

endpackage

// File: rtl/chunk_norm.sv
module chunk_norm #(
    parameter int CFG_W     = 11,
    parameter int LEN_W     = 11,
    parameter int MAX_BYTES = 1024
) (
    input  logic [CFG_W-1:0] size_cfg,
    output logic [LEN_W-1:0] size_bytes
);
    logic [CFG_W-1:0] aligned;

    assign aligned = {size_cfg[CFG_W-1:2], 2'b00};

    always_comb begin
        if (aligned == '0)
            size_bytes = LEN_W'(4);
        else if (aligned > CFG_W'(MAX_BYTES))
            size_bytes = LEN_W'(MAX_BYTES);
        else
            size_bytes = LEN_W'(aligned);
    end
endmodule

// File: rtl/blk_len.sv
module blk_len #(
    parameter int LEN_W = 11,
    parameter int REM_W = 5
) (
    input  logic             unbounded,
    input  logic [REM_W-1:0] rem_beats,
    input  logic [LEN_W-1:0] size_bytes,
    output logic [LEN_W-1:0] len_bytes
);
    logic [REM_W-1:0] eff_rem;
    logic [LEN_W-1:0] want;

    assign eff_rem = (rem_beats == '0) ? REM_W'(1) : rem_beats;
    assign want    = LEN_W'(eff_rem) << 2;

    always_comb begin
        if (unbounded || (want > size_bytes))
            len_bytes = size_bytes;
        else
            len_bytes = want;
    end
endmodule

// File: rtl/ahb_burst_splitter.sv
module ahb_burst_splitter
    import splitter_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CFG_W     = 11,
    parameter int LEN_W     = 11,
    parameter int MAX_BYTES = 1024,
    parameter int REM_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsel,
    input  logic [AW-1:0]    haddr,
    input  logic [1:0]       htrans,
    input  logic             hwrite,
    input  logic [2:0]       hburst,
    input  logic [DW-1:0]    hwdata,
    input  logic             hready_in,
    output logic             hreadyout,
    output logic             hresp,
    output logic [DW-1:0]    hrdata,
    input  logic [CFG_W-1:0] rd_size_cfg,
    input  logic [CFG_W-1:0] wr_size_cfg,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [AW-1:0]    cmd_addr,
    output logic [LEN_W-1:0] cmd_len,
    output logic             cmd_write,
    output logic             wd_valid,
    input  logic             wd_ready,
    output logic [DW-1:0]    wd_data,
    output logic             wd_last,
    input  logic             rd_valid,
    output logic             rd_ready,
    input  logic [DW-1:0]    rd_data
);
    localparam int BEAT_W = LEN_W - 2;
    localparam int NDIR   = 2;

    typedef struct packed {
        split_state_e     st;
        logic [AW-1:0]    addr;
        logic             wr;
        logic             unbounded;
        logic             wrap;
        logic [REM_W-1:0] rem;
        logic [LEN_W-1:0] len;
        logic [BEAT_W-1:0] beats;
        logic [BEAT_W-1:0] drain;
    } split_regs_t;

    split_regs_t q, d;

    // per-direction normalised block sizes: index 0 read, 1 write
    logic [LEN_W-1:0] size_norm [NDIR];
    for (genvar g = 0; g < NDIR; g++) begin : g_size
        chunk_norm #(.CFG_W(CFG_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) i_norm (
            .size_cfg   ((g == 0) ? rd_size_cfg : wr_size_cfg),
            .size_bytes (size_norm[g])
        );
    end

    logic             accept, is_nonseq, seq_next, cont, beat_done;
    logic             cap_unb, cap_wrap;
    logic [REM_W-1:0] rem_dec, cap_rem;
    logic [LEN_W-1:0] cap_len;

    assign accept    = hsel && hready_in && htrans[1];
    assign is_nonseq = (htrans == HT_NONSEQ);
    assign seq_next  = hsel && (htrans == HT_SEQ);
    assign cont      = seq_next && (q.beats > BEAT_W'(1));
    assign beat_done = (q.st == ST_XFER) && (q.wr ? wd_ready : rd_valid);
    assign rem_dec   = (q.rem != '0) ? (q.rem - REM_W'(1)) : q.rem;

    // parameters of a block opened by the transfer now in its address phase
    always_comb begin
        cap_unb  = is_nonseq ? (hburst == 3'd1) : q.unbounded;
        cap_wrap = is_nonseq ? is_wrap(hburst) : q.wrap;
        if (is_nonseq)
            cap_rem = REM_W'(fixed_beats(hburst));
        else if (q.wrap)
            cap_rem = REM_W'(1);
        else if (q.st == ST_XFER)
            cap_rem = rem_dec;
        else
            cap_rem = q.rem;
    end

    blk_len #(.LEN_W(LEN_W), .REM_W(REM_W)) i_blk_len (
        .unbounded  (cap_unb),
        .rem_beats  (cap_rem),
        .size_bytes (hwrite ? size_norm[1] : size_norm[0]),
        .len_bytes  (cap_len)
    );

    always_comb begin
        d = q;
        if ((q.drain != '0) && rd_valid)
            d.drain = q.drain - BEAT_W'(1);
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st        = ST_CMD;
                    d.addr      = haddr;
                    d.wr        = hwrite;
                    d.unbounded = cap_unb;
                    d.wrap      = cap_wrap;
                    d.rem       = cap_rem;
                    d.len       = cap_len;
                    d.beats     = BEAT_W'(cap_len >> 2);
                end
            end
            ST_CMD: begin
                if (cmd_valid && cmd_ready)
                    d.st = ST_XFER;
            end
            ST_XFER: begin
                if (beat_done) begin
                    d.addr  = q.addr + AW'(4);
                    d.beats = q.beats - BEAT_W'(1);
                    d.rem   = rem_dec;
                    if (!cont) begin
                        if (!q.wr && (q.beats > BEAT_W'(1)))
                            d.drain = q.beats - BEAT_W'(1);
                        if (accept) begin
                            d.st        = ST_CMD;
                            d.addr      = haddr;
                            d.wr        = hwrite;
                            d.unbounded = cap_unb;
                            d.wrap      = cap_wrap;
                            d.rem       = cap_rem;
                            d.len       = cap_len;
                            d.beats     = BEAT_W'(cap_len >> 2);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    always_comb begin
        case (q.st)
            ST_IDLE: hreadyout = 1'b1;
            ST_CMD:  hreadyout = 1'b0;
            ST_XFER: hreadyout = q.wr ? wd_ready : rd_valid;
            default: hreadyout = 1'b1;
        endcase
    end

    assign hresp     = 1'b0;
    assign hrdata    = rd_data;
    assign cmd_valid = (q.st == ST_CMD) && (q.drain == '0);
    assign cmd_addr  = q.addr;
    assign cmd_len   = q.len;
    assign cmd_write = q.wr;
    assign wd_valid  = (q.st == ST_XFER) && q.wr;
    assign wd_data   = hwdata;
    assign wd_last   = (q.beats == BEAT_W'(1)) || !seq_next;
    assign rd_ready  = ((q.st == ST_XFER) && !q.wr) || (q.drain != '0);

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_write)); // R11
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0) && (cmd_len[1:0] == 2'b00) && (cmd_len <= LEN_W'(MAX_BYTES))); // R4
    AST_NO_CMD_MID_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !wd_valid && !rd_ready); // R5
    AST_STALL_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !hreadyout); // R10
    AST_BLOCK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER) |-> (q.beats != '0)); // R3
endmodule

// File: tb/test_ahb_burst_splitter.sv
module test_ahb_burst_splitter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hsel;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hburst;
    logic [31:0] hwdata;
    logic        hready_in;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;
    logic [10:0] rd_cfg, wr_cfg;
    logic        cmd_valid, cmd_ready, cmd_write;
    logic [31:0] cmd_addr;
    logic [10:0] cmd_len;
    logic        wd_valid, wd_ready, wd_last;
    logic [31:0] wd_data;
    logic        rd_valid, rd_ready;
    logic [31:0] rd_data;

    int errors = 0, checks = 0;
    int gate_err = 0, resp_err = 0;
    bit stall = 0, done = 0;

    logic [31:0] mem [0:255];
    logic [31:0] log_addr [0:63];
    logic [10:0] log_len [0:63];
    logic        log_wr [0:63];
    int          log_n = 0;
    logic [31:0] rdbuf [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign hready_in = hreadyout;

    ahb_burst_splitter i_ahb_burst_splitter (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hburst(hburst), .hwdata(hwdata), .hready_in(hready_in),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .rd_size_cfg(rd_cfg), .wr_size_cfg(wr_cfg),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_last(wd_last),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_cmd(input string req, input int idx, input logic [31:0] a,
                           input logic [10:0] l, input logic w);
        chk({req, " cmd addr"}, log_addr[idx], a);
        chk({req, " cmd len"}, 32'(log_len[idx]), 32'(l));
        chk({req, " cmd dir"}, 32'(log_wr[idx]), 32'(w));
    endtask

    // memory core model: one block at a time
    initial begin
        cmd_ready = 0; wd_ready = 0; rd_valid = 0; rd_data = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
        @(posedge rst_n);
        forever begin
            logic [31:0] c_a; logic [10:0] c_l; logic c_w; bit got, moved, lastf;
            logic [7:0] wi;
            @(posedge clk); #1;
            if (stall) begin repeat (2) @(posedge clk); #1; end
            cmd_ready = 1;
            got = 0;
            while (!got) begin
                @(negedge clk);
                got = cmd_valid; c_a = cmd_addr; c_l = cmd_len; c_w = cmd_write;
                @(posedge clk); #1;
            end
            cmd_ready = 0;
            log_addr[log_n] = c_a; log_len[log_n] = c_l; log_wr[log_n] = c_w;
            if (log_n < 63) log_n++;
            for (int k = 0; k < int'(c_l >> 2); k++) begin
                wi = c_a[9:2] + 8'(k);
                moved = 0; lastf = 0;
                if (c_w) wd_ready = 1; else begin rd_valid = 1; rd_data = mem[wi]; end
                while (!moved) begin
                    @(negedge clk);
                    if (cmd_valid) gate_err++;
                    if (c_w && wd_valid) begin mem[wi] = wd_data; lastf = wd_last; moved = 1; end
                    if (!c_w && rd_ready) moved = 1;
                    @(posedge clk); #1;
                end
                wd_ready = 0; rd_valid = 0;
                if (stall) begin @(posedge clk); #1; end
                if (lastf) break;
            end
        end
    end

    always @(negedge clk) if (rst_n === 1'b1 && hresp !== 1'b0) resp_err++;

    task automatic ahb_burst(input bit wr, input logic [31:0] a, input int n,
                             input logic [2:0] kind, input logic [31:0] seed);
        for (int i = 0; i <= n; i++) begin
            bit rdy;
            if (i < n) begin
                hsel = 1; htrans = (i == 0) ? 2'b10 : 2'b11;
                haddr = a + 32'(4 * i); hwrite = wr; hburst = kind;
            end else begin
                hsel = 0; htrans = 2'b00;
            end
            if (i > 0 && wr) hwdata = seed + 32'(i - 1);
            rdy = 0;
            while (!rdy) begin
                @(negedge clk);
                rdy = hreadyout;
                if (rdy && i > 0 && !wr) rdbuf[i-1] = hrdata;
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 hreadyout in reset", 32'(hreadyout), 32'd1);
        chk("R1 cmd_valid in reset", 32'(cmd_valid), 32'd0);
        chk("R1 wd_valid in reset", 32'(wd_valid), 32'd0);
        chk("R1 rd_ready in reset", 32'(rd_ready), 32'd0);
    endtask

    task automatic t_incr_write();
        int b = log_n;
        wr_cfg = 11'd16;
        ahb_burst(1, 32'h100, 10, 3'd1, 32'h1111_0000);
        settle();
        chk("R3 write block count", 32'(log_n - b), 32'd3);
        chk_cmd("R3 wr0", b, 32'h100, 11'd16, 1'b1);
        chk_cmd("R3 wr1", b + 1, 32'h110, 11'd16, 1'b1);
        chk_cmd("R3 wr2", b + 2, 32'h120, 11'd16, 1'b1);
        for (int i = 0; i < 10; i++) chk("R10 write data", mem[64 + i], 32'h1111_0000 + 32'(i));
        chk("R7 no write past early end", mem[74], 32'hA000_004A);
    endtask

    task automatic t_incr_read();
        int b = log_n;
        rd_cfg = 11'd8;
        ahb_burst(0, 32'h100, 6, 3'd1, 32'h0);
        settle();
        chk("R3 read block count", 32'(log_n - b), 32'd3);
        chk_cmd("R3 rd0", b, 32'h100, 11'd8, 1'b0);
        chk_cmd("R3 rd2", b + 2, 32'h110, 11'd8, 1'b0);
        for (int i = 0; i < 6; i++) chk("R10 read data", rdbuf[i], 32'h1111_0000 + 32'(i));
    endtask

    task automatic t_read_early();
        int b = log_n;
        rd_cfg = 11'd16;
        ahb_burst(0, 32'h200, 3, 3'd1, 32'h0);
        for (int i = 0; i < 3; i++) chk("R8 early read data", rdbuf[i], 32'hA000_0080 + 32'(i));
        ahb_burst(0, 32'h300, 1, 3'd0, 32'h0);
        settle();
        chk("R6 blocks after drain", 32'(log_n - b), 32'd2);
        chk_cmd("R8 early", b, 32'h200, 11'd16, 1'b0);
        chk_cmd("R9 single", b + 1, 32'h300, 11'd4, 1'b0);
        chk("R8 next read own data", rdbuf[0], 32'hA000_00C0);
    endtask

    task automatic t_norm();
        int b = log_n;
        rd_cfg = 11'd0;
        ahb_burst(0, 32'h100, 2, 3'd1, 32'h0);
        settle();
        chk_cmd("R4 zero->4 a", b, 32'h100, 11'd4, 1'b0);
        chk_cmd("R4 zero->4 b", b + 1, 32'h104, 11'd4, 1'b0);
        chk("R4 zero size data", rdbuf[1], 32'h1111_0001);
        b = log_n;
        wr_cfg = 11'd13;
        ahb_burst(1, 32'h180, 3, 3'd1, 32'h3333_0000);
        settle();
        chk("R4 13->12 count", 32'(log_n - b), 32'd1);
        chk_cmd("R4 13->12", b, 32'h180, 11'd12, 1'b1);
        chk("R4 13->12 data", mem[98], 32'h3333_0002);
        b = log_n;
        rd_cfg = 11'd2000;
        ahb_burst(0, 32'h000, 2, 3'd1, 32'h0);
        settle();
        chk_cmd("R4 cap 1024", b, 32'h000, 11'd1024, 1'b0);
        chk("R4 cap data", rdbuf[1], 32'hA000_0001);
    endtask

    task automatic t_fixed();
        int b = log_n;
        wr_cfg = 11'd1024;
        ahb_burst(1, 32'h040, 4, 3'd3, 32'h4444_0000);
        settle();
        chk("R9 incr4 count", 32'(log_n - b), 32'd1);
        chk_cmd("R9 incr4", b, 32'h040, 11'd16, 1'b1);
        chk("R9 incr4 data", mem[19], 32'h4444_0003);
        b = log_n;
        wr_cfg = 11'd8;
        ahb_burst(1, 32'h060, 8, 3'd5, 32'h8888_0000);
        settle();
        chk("R9 incr8 split count", 32'(log_n - b), 32'd4);
        chk_cmd("R9 incr8 last", b + 3, 32'h078, 11'd8, 1'b1);
        chk("R9 incr8 data", mem[31], 32'h8888_0007);
        b = log_n;
        rd_cfg = 11'd16;
        ahb_burst(0, 32'h044, 1, 3'd0, 32'h0);
        settle();
        chk_cmd("R9 single read", b, 32'h044, 11'd4, 1'b0);
        chk("R9 single data", rdbuf[0], 32'h4444_0001);
        b = log_n;
        ahb_burst(0, 32'h060, 2, 3'd2, 32'h0);
        settle();
        chk("R9 wrap count", 32'(log_n - b), 32'd2);
        chk_cmd("R9 wrap", b + 1, 32'h064, 11'd4, 1'b0);
        chk("R9 wrap data", rdbuf[1], 32'h8888_0001);
    endtask

    task automatic t_stall();
        int b = log_n;
        stall = 1; wr_cfg = 11'd8; rd_cfg = 11'd8;
        ahb_burst(1, 32'h380, 5, 3'd1, 32'h7777_0000);
        settle();
        chk("R5 stalled write count", 32'(log_n - b), 32'd3);
        chk_cmd("R11 stalled write", b + 2, 32'h390, 11'd8, 1'b1);
        ahb_burst(0, 32'h380, 5, 3'd1, 32'h0);
        settle();
        for (int i = 0; i < 5; i++) chk("R6 stalled read data", rdbuf[i], 32'h7777_0000 + 32'(i));
        chk("R7 stalled early write end", mem[229], 32'hA000_00E5);
        stall = 0;
        chk("R5 R6 no command mid block", 32'(gate_err), 32'd0);
        chk("R2 response always okay", 32'(resp_err), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; hsel = 0; htrans = 2'b00; haddr = '0; hwrite = 0; hburst = 3'd0;
        hwdata = '0; rd_cfg = 11'd16; wr_cfg = 11'd16;
        repeat (3) @(posedge clk);
        t_reset();
        @(posedge clk); #1;
        rst_n = 1;
        t_reset();
        @(posedge clk); #1;
        t_incr_write();
        t_incr_read();
        t_read_early();
        t_norm();
        t_fixed();
        t_stall();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule